// File: doc/BRIEF.md
# Serial Control Word Receiver

This block is the device-side receiver for a three-wire control port made of an active-low select line, a serial clock and a data line. All three lines are brought into the fast system clock domain through two-stage synchronisers. Edges are detected on the synchronised copies. While select is low, each rising serial clock edge shifts one data bit into a 16-bit word, least significant bit first. When select rises and exactly sixteen bits have arrived, the frame is complete and the word may update the control register.

After reset the register holds a fixed default. The first complete frame is consumed as a dummy and does not update the register. The second complete frame is the first real data. The top bit of the word selects a low-power bias mode. When a frame clears that bit while bias mode is active, the register returns to its defaults, which cancels bias mode. That frame counts as the dummy, so the next complete frame is again real data. The register is presented as individual enable, power-down and mute bits, a record/playback select, a filter-trap select and a 5-bit volume code.

Top module: `serial_ctl_rx`

## Requirements
- R1: A complete frame loads word bit k from the k-th data bit sent, where the first bit sent is bit 0. The outputs map the word as follows: bit 0 mute_xstr_on_o, bit 1 ref_charge_on_o, bit 2 mic_pd_o, bit 3 alc_pd_o, bit 4 rec_sel_o, bit 5 trap_8k_o, bit 6 rec_amp_pd_o, bit 7 line_pd_o, bit 8 line_mute_o, bit 9 spk_pd_o, bits 14:10 vol_o, bit 15 bias_o.
- R2: During and after reset the register value is 0x03EF. That is bits 0 to 3 set, bit 4 clear, bits 5 to 9 set, and bits 10 to 15 clear.
- R3: The first complete frame after reset leaves the register at 0x03EF.
- R4: Each complete frame after the dummy loads the register when select rises. The outputs do not change while a frame is still being shifted in.
- R5: A frame with fewer or more than 16 rising clock edges leaves the register unchanged. Such a frame does not count as the dummy frame.
- R6: While bias_o is 1, a complete frame with bit 15 clear sets the register to 0x03EF instead of loading the word. The following complete frame is loaded as real data.
- R7: While bias_o is 1, a complete frame with bit 15 set is loaded as normal data.
- R8: vol_o takes word bits 10 to 14 with weights 1, 2, 4, 8 and 16. Code 0 is minimum (mute) and code 31 is maximum, and both extremes load exactly.
- R9: The register update becomes visible within 8 system clock cycles of select rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on pulse) |
| cs_n_i | input | 1 | Serial select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, data sampled on rising edge, asynchronous |
| sdata_i | input | 1 | Serial data, least significant bit first, asynchronous |
| mute_xstr_on_o | output | 1 | Line mute transistor on (word bit 0) |
| ref_charge_on_o | output | 1 | Reference charging switch on (word bit 1) |
| mic_pd_o | output | 1 | Mic amp power down (word bit 2) |
| alc_pd_o | output | 1 | Level-control amp power down (word bit 3) |
| rec_sel_o | output | 1 | 1 = record, 0 = playback (word bit 4) |
| trap_8k_o | output | 1 | Filter trap select, 1 = 8 kHz, 0 = 16 kHz (word bit 5) |
| rec_amp_pd_o | output | 1 | Record amp power down (word bit 6) |
| line_pd_o | output | 1 | Line output power down (word bit 7) |
| line_mute_o | output | 1 | Line mute (word bit 8) |
| spk_pd_o | output | 1 | Speaker amp power down (word bit 9) |
| vol_o | output | 5 | Volume code (word bits 14:10) |
| bias_o | output | 1 | Bias mode (word bit 15) |

## Verification
The bench uses several kinds of frame. A directed walk follows the arming sequence: one dummy frame, then real data, then the minimum and maximum volume codes. Frames of 15 and 17 bits check that a wrong length neither loads the register nor takes the place of the dummy. A directed walk through bias mode covers both cases in bias mode: a frame that keeps bit 15 set and loads, and a frame that clears it and only restores defaults. A second reset followed by a random stream of words and lengths checks the bit ordering and the arming logic together. The bench also checks the register in the middle of a frame, so an early load is detected and not confused with a correct one at the end of the frame.

// File: rtl/serial_ctl_pkg.sv
package serial_ctl_pkg;
    localparam int unsigned WORD_W   = 16;
    localparam int unsigned VOL_W    = 5;
    localparam int unsigned VOL_LSB  = 10;
    localparam int unsigned BIAS_BIT = 15;
    localparam logic [WORD_W-1:0] RESET_WORD = 16'h03EF;

    localparam int unsigned B_MUTE_XSTR = 0;
    localparam int unsigned B_REF_CHG   = 1;
    localparam int unsigned B_MIC_PD    = 2;
    localparam int unsigned B_ALC_PD    = 3;
    localparam int unsigned B_REC_SEL   = 4;
    localparam int unsigned B_TRAP_8K   = 5;
    localparam int unsigned B_REC_PD    = 6;
    localparam int unsigned B_LINE_PD   = 7;
    localparam int unsigned B_LINE_MUTE = 8;
    localparam int unsigned B_SPK_PD    = 9;

    // arming state of the register path
    typedef enum logic {
        ARM_PRIME = 1'b0,   // waiting for the dummy frame
        ARM_LIVE  = 1'b1    // complete frames carry real data
    } arm_e;
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
    parameter int unsigned N      = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] lvl_o
);
    typedef struct packed {
        logic [STAGES-1:0][N-1:0] pipe;
    } sync_s;

    sync_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.pipe[0] = raw_i;
        for (int i = 1; i < STAGES; i++) begin
            s_d.pipe[i] = s_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                s_q.pipe[i] <= RST_VAL;
            end
        end else begin
            s_q <= s_d;
        end
    end

    assign lvl_o = s_q.pipe[STAGES-1];
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_lvl_i,
    input  logic              sclk_lvl_i,
    input  logic              sdata_lvl_i,
    output logic [WORD_W-1:0] word_o,
    output logic              done_o,
    output logic              ok_o
);
    localparam int unsigned CNT_MAX = WORD_W + 1;
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        logic [WORD_W-1:0] shift;
        logic [CNT_W-1:0]  cnt;
        logic              cs_prev;
        logic              sclk_prev;
        logic              done;
        logic              ok;
    } shf_s;

    shf_s s_d, s_q;
    logic cs_rise, cs_fall, sclk_rise;

    always_comb begin
        cs_rise   = cs_n_lvl_i && !s_q.cs_prev;
        cs_fall   = !cs_n_lvl_i && s_q.cs_prev;
        sclk_rise = sclk_lvl_i && !s_q.sclk_prev;

        s_d           = s_q;
        s_d.cs_prev   = cs_n_lvl_i;
        s_d.sclk_prev = sclk_lvl_i;
        s_d.done      = 1'b0;
        s_d.ok        = 1'b0;

        if (cs_fall) begin
            s_d.cnt = '0;
        end
        if (!cs_n_lvl_i && sclk_rise) begin
            s_d.shift = {sdata_lvl_i, s_q.shift[WORD_W-1:1]};
            if (s_d.cnt != CNT_W'(CNT_MAX)) begin
                s_d.cnt = s_d.cnt + 1'b1;
            end
        end
        if (cs_rise) begin
            s_d.done = 1'b1;
            s_d.ok   = (s_q.cnt == CNT_W'(WORD_W));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.shift     <= '0;
            s_q.cnt       <= '0;
            s_q.cs_prev   <= 1'b1;
            s_q.sclk_prev <= 1'b0;
            s_q.done      <= 1'b0;
            s_q.ok        <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign word_o = s_q.shift;
    assign done_o = s_q.done;
    assign ok_o   = s_q.ok;

    // R5: the edge count saturates and never wraps back into a legal length
    a_r5_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(CNT_MAX));
    // R4: one frame end gives one single-cycle completion pulse
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R5: a length verdict is only ever given at a frame end
    a_r5_ok_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        ok_o |-> done_o);
endmodule

// File: rtl/ctrl_word_reg.sv
module ctrl_word_reg
    import serial_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic              ok_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] reg_o
);
    typedef struct packed {
        arm_e              arm;
        logic [WORD_W-1:0] value;
    } ctl_s;

    ctl_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (done_i && ok_i) begin
            if (s_q.arm == ARM_PRIME) begin
                s_d.arm = ARM_LIVE;
            end else if (s_q.value[BIAS_BIT] && !word_i[BIAS_BIT]) begin
                s_d.value = RESET_WORD;
                s_d.arm   = ARM_LIVE;
            end else begin
                s_d.value = word_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.arm   <= ARM_PRIME;
            s_q.value <= RESET_WORD;
        end else begin
            s_q <= s_d;
        end
    end

    assign reg_o = s_q.value;

    // R3: until the dummy frame has been consumed the defaults hold
    a_r3_prime_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.arm == ARM_PRIME) |-> (reg_o == RESET_WORD));
    // R4: nothing but a frame end can move the register
    a_r4_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable(reg_o));
    // R5: a frame of the wrong length changes neither register nor arming
    a_r5_bad_len_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !ok_i) |=> ($stable(reg_o) && $stable(s_q.arm)));
    // R6: leaving bias mode always lands on the defaults
    a_r6_bias_exit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(reg_o[BIAS_BIT]) && !reg_o[BIAS_BIT]) |-> (reg_o == RESET_WORD));
endmodule

// File: rtl/serial_ctl_rx.sv
module serial_ctl_rx
    import serial_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n_i,
    input  logic             sclk_i,
    input  logic             sdata_i,
    output logic             mute_xstr_on_o,
    output logic             ref_charge_on_o,
    output logic             mic_pd_o,
    output logic             alc_pd_o,
    output logic             rec_sel_o,
    output logic             trap_8k_o,
    output logic             rec_amp_pd_o,
    output logic             line_pd_o,
    output logic             line_mute_o,
    output logic             spk_pd_o,
    output logic [VOL_W-1:0] vol_o,
    output logic             bias_o
);
    localparam int unsigned N_LINES = 3;

    logic [N_LINES-1:0] lines_lvl;
    logic [WORD_W-1:0]  rx_word;
    logic               rx_done;
    logic               rx_ok;
    logic [WORD_W-1:0]  ctl;

    // line order: {data, clock, select}; select idles high
    sync_chain #(
        .N      (N_LINES),
        .STAGES (2),
        .RST_VAL(3'b001)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw_i({sdata_i, sclk_i, cs_n_i}),
        .lvl_o(lines_lvl)
    );

    frame_shifter #(.WORD_W(WORD_W)) u_shf (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_lvl_i (lines_lvl[0]),
        .sclk_lvl_i (lines_lvl[1]),
        .sdata_lvl_i(lines_lvl[2]),
        .word_o     (rx_word),
        .done_o     (rx_done),
        .ok_o       (rx_ok)
    );

    ctrl_word_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .done_i(rx_done),
        .ok_i  (rx_ok),
        .word_i(rx_word),
        .reg_o (ctl)
    );

    assign mute_xstr_on_o  = ctl[B_MUTE_XSTR];
    assign ref_charge_on_o = ctl[B_REF_CHG];
    assign mic_pd_o        = ctl[B_MIC_PD];
    assign alc_pd_o        = ctl[B_ALC_PD];
    assign rec_sel_o       = ctl[B_REC_SEL];
    assign trap_8k_o       = ctl[B_TRAP_8K];
    assign rec_amp_pd_o    = ctl[B_REC_PD];
    assign line_pd_o       = ctl[B_LINE_PD];
    assign line_mute_o     = ctl[B_LINE_MUTE];
    assign spk_pd_o        = ctl[B_SPK_PD];
    assign vol_o           = ctl[VOL_LSB +: VOL_W];
    assign bias_o          = ctl[BIAS_BIT];

    // R4: outputs hold while select is low (a frame in flight)
    a_r4_quiet_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_i && $past(!cs_n_i) && $past(!cs_n_i, 2) && $past(!cs_n_i, 3)
         && $past(!cs_n_i, 4) && $past(!cs_n_i, 5))
        |-> $stable(ctl));
endmodule

// File: tb/serial_ctl_rx_tb.sv
module serial_ctl_rx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 4;
    localparam logic [15:0] DEF = 16'h03EF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b1, sdata = 1'b0;
    logic mute_xstr_on, ref_charge_on, mic_pd, alc_pd, rec_sel, trap_8k;
    logic rec_amp_pd, line_pd, line_mute, spk_pd, bias;
    logic [4:0] vol;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    bit m_live = 0;
    logic [15:0] m_reg = DEF;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_ctl_rx u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdata_i(sdata),
        .mute_xstr_on_o(mute_xstr_on), .ref_charge_on_o(ref_charge_on),
        .mic_pd_o(mic_pd), .alc_pd_o(alc_pd), .rec_sel_o(rec_sel),
        .trap_8k_o(trap_8k), .rec_amp_pd_o(rec_amp_pd), .line_pd_o(line_pd),
        .line_mute_o(line_mute), .spk_pd_o(spk_pd), .vol_o(vol), .bias_o(bias)
    );

    function automatic logic [15:0] observed();
        return {bias, vol, spk_pd, line_mute, line_pd, rec_amp_pd, trap_8k,
                rec_sel, alc_pd, mic_pd, ref_charge_on, mute_xstr_on};
    endfunction

    // expected register after a frame, from the requirements
    function automatic logic [15:0] next_reg(input bit live, input logic [15:0] cur,
                                             input logic [15:0] w, input int nbits);
        if (nbits != 16 || !live) return cur;
        if (cur[15] && !w[15]) return DEF;
        return w;
    endfunction

    task automatic check(input string req, input logic [15:0] exp);
        @(negedge clk);
        checks++;
        if (observed() !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, observed(), exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b1;
        repeat (3) @(posedge clk);
        check("R2 in reset", DEF);
        rst_n = 1'b1;
        m_live = 0; m_reg = DEF;
        repeat (4) @(posedge clk);
        check("R2 after reset", DEF);
    endtask

    // send nbits of w (bit index wraps above 15), then update the model
    task automatic send(input logic [15:0] w, input int nbits, input string req);
        cs_n = 1'b0;
        repeat (HALF_BIT) @(posedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdata = w[i % 16];
            sclk = 1'b0;
            repeat (HALF_BIT) @(posedge clk);
            sclk = 1'b1;
            repeat (HALF_BIT) @(posedge clk);
            if (i == nbits / 2) check({req, " R4 mid-frame hold"}, m_reg);
        end
        repeat (HALF_BIT) @(posedge clk);
        check({req, " R4 hold before select rises"}, m_reg);
        cs_n = 1'b1;
        if (nbits == 16 && !m_live) m_live = 1;
        else m_reg = next_reg(m_live, m_reg, w, nbits);
        repeat (8) @(posedge clk);
        check({req, " R9 visible within 8 cycles"}, m_reg);
        repeat (4) @(posedge clk);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        do_reset();
        send(16'h1234, 16, "R3 dummy discarded");
        check("R3", DEF);
        do_reset();
        send(16'h0000, 15, "R5 short frame");
        send(16'h0000, 17, "R5 long frame");
        send(16'h0000, 16, "R5 dummy still due");
        check("R5 dummy after bad frames", DEF);
        send(16'h2A5C, 16, "R1 first real load");
        send(16'h0000, 16, "R8 vol min");
        check("R8 vol=0", 16'h0000);
        send(16'h7C00, 16, "R8 vol max");
        check("R8 vol=31", 16'h7C00);
        send(16'h5555, 14, "R5 short while live");
        send(16'h8123, 16, "R7 enter bias");
        send(16'hFC0F, 16, "R7 bias kept loads");
        check("R7", 16'hFC0F);
        send(16'h1111, 16, "R6 bias exit restores defaults");
        check("R6", DEF);
        send(16'h4321, 16, "R6 next frame real");
        check("R6 follow-up", 16'h4321);
        do_reset();
        for (int n = 0; n < 150; n++) begin
            logic [15:0] w;
            int nb;
            w = 16'($urandom);
            if ($urandom_range(0, 3) != 0) w[15] = 1'b0;
            nb = ($urandom_range(0, 7) == 0) ? 15 + 2 * $urandom_range(0, 1) : 16;
            send(w, nb, "R1 random");
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hung expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule